// File: doc/BRIEF.md
# Secure Address Window Guard

The guard sits beside a memory controller and decides, for every memory access presented to it, whether the access may proceed or must be aborted. Software programs a bank of address window descriptors through a 32-bit register port. Each descriptor names a naturally aligned window whose size is a power of two. The window size is 4 KB shifted left by a 5-bit length code. Each descriptor also carries a two-bit permission code. Descriptor 0 also holds the permission that applies to any address no valid window covers.

An access carries an address and a read/write direction. It is compared against every valid window at once. The lowest-numbered window that matches supplies the permission. If no window matches, the fallback permission applies. The allow/abort verdict is registered and appears one cycle after the access is presented.

Two control bits protect the configuration. A one-way lock bit freezes every descriptor once it is set, and only reset clears it. A security bit makes the register port refuse accesses flagged as non-secure.

Top module: `srg_guard`

## Requirements
- R1: After reset, every descriptor reads as zero (invalid), the lock and security bits read 0, and every access of either direction is allowed.
- R2: The descriptor i word sits at register offset 0x80 + 8*i and holds: bit 0 valid, bits 2:1 permission, bit 3 enable flag, bits 11:7 length code, bits 31:12 start address. Bits 6:4 are stored only in descriptor 0; in other descriptors they read 0. The word at 0x84 + 8*i reads 0 and ignores writes.
- R3: A valid descriptor with code c covers the 4 KB << c bytes that begin at its start address with the low 12 + c address bits cleared. Start address bits below the window size do not affect the match, and code 31 covers the whole 32-bit space.
- R4: The permission codes are 0 = read and write allowed, 1 = read only, 2 = write only, 3 = every access aborted. A write is denied under codes 1 and 3, and a read is denied under codes 2 and 3.
- R5: An access that no valid window covers takes the permission in bits 5:4 of descriptor 0, using the same codes as R4.
- R6: When several valid windows cover an access, the lowest-numbered one decides the verdict.
- R7: A descriptor with bit 0 clear never matches, whatever its other fields hold.
- R8: chk_valid and chk_allow are updated on the clock edge that samples acc_valid high, so they appear one cycle after the access. chk_valid is low in the cycle after an idle cycle.
- R9: Writing 1 to bit 31 of offset 0x044 sets the lock, and that bit reads back as 1. Writing 0 does not clear it; only reset does.
- R10: While locked, writes to descriptors change neither the readback nor the verdicts.
- R11: Bit 0 of offset 0x048 is the security bit. While it is 1, a register access with reg_nonsec high reads 0 and its write is ignored. Accesses with reg_nonsec low are served as normal.
- R12: The enable flags (bit 3 of each descriptor, and bit 6 of descriptor 0) are stored and read back, but they do not change any verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_nonsec | input | 1 | Register access is flagged non-secure |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| acc_valid | input | 1 | Memory access present |
| acc_addr | input | 32 | Memory access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| chk_valid | output | 1 | Verdict present (one cycle after acc_valid) |
| chk_allow | output | 1 | 1 = allow, 0 = abort |

## Verification
The bench builds the guard with its default parameters: sixteen descriptors, a 12-bit register offset, the lock at bit 31 and the security bit at bit 0. With sixteen descriptors, the bench can program overlapping windows in low and high slots. It can also leave an invalid descriptor between them and program a window as large as half the address space. This makes priority, window edges, invalid slots and the fallback permission observable at the ports in one configuration. The full register offset range also lets the bench reach the unused high words next to the last descriptors.

// File: rtl/srg_pkg.sv
package srg_pkg;
   localparam int ADDR_W     = 32;
   localparam int DATA_W     = 32;
   localparam int GRAN_SHIFT = 12;
   localparam int START_W    = ADDR_W - GRAN_SHIFT;
   localparam int CODE_W     = 5;

   // descriptor word field positions
   localparam int F_VALID   = 0;
   localparam int F_PERM    = 1;
   localparam int F_EN      = 3;
   localparam int F_UR_PERM = 4;
   localparam int F_UR_EN   = 6;
   localparam int F_CODE    = 7;

   typedef enum logic [1:0] {
      PERM_RW    = 2'd0,
      PERM_RO    = 2'd1,
      PERM_WO    = 2'd2,
      PERM_ABORT = 2'd3
   } perm_e;

   function automatic logic perm_allows(perm_e p, logic is_write);
      logic ok;
      case (p)
         PERM_RW: ok = 1'b1;
         PERM_RO: ok = ~is_write;
         PERM_WO: ok = is_write;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction
endpackage

// File: rtl/srg_regs.sv
module srg_regs
   import srg_pkg::*;
#(
   parameter int NUM_RANGES = 16,
   parameter int REG_AW     = 12,
   parameter int DESC_BASE  = 'h80,
   parameter int CTRL_OFS   = 'h44,
   parameter int SEC_OFS    = 'h48,
   parameter int LOCK_BIT   = 31,
   parameter int SEC_BIT    = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_we,
   input  logic [REG_AW-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   input  logic                    reg_nonsec,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic [NUM_RANGES-1:0]   valid_o,
   output perm_e                   perm_o  [NUM_RANGES],
   output logic [START_W-1:0]      start_o [NUM_RANGES],
   output logic [CODE_W-1:0]       code_o  [NUM_RANGES],
   output perm_e                   ur_perm_o
);
   localparam int STRIDE = 8;

   logic [NUM_RANGES-1:0] valid_q;
   logic [NUM_RANGES-1:0] en_q;
   perm_e                 perm_q  [NUM_RANGES];
   logic [START_W-1:0]    start_q [NUM_RANGES];
   logic [CODE_W-1:0]     code_q  [NUM_RANGES];
   perm_e                 ur_perm_q;
   logic                  ur_en_q;
   logic                  lock_q;
   logic                  sec_q;

   logic sec_block;
   logic wr_ok;
   assign sec_block = sec_q & reg_nonsec;
   assign wr_ok     = reg_we & ~sec_block;

   function automatic logic [REG_AW-1:0] desc_ofs(int idx);
      return REG_AW'(DESC_BASE + STRIDE * idx);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q    <= 1'b0;
         sec_q     <= 1'b0;
         valid_q   <= '0;
         en_q      <= '0;
         ur_perm_q <= PERM_RW;
         ur_en_q   <= 1'b0;
         for (int i = 0; i < NUM_RANGES; i++) begin
            perm_q[i]  <= PERM_RW;
            start_q[i] <= '0;
            code_q[i]  <= '0;
         end
      end else if (wr_ok) begin
         if (reg_addr == REG_AW'(CTRL_OFS) && reg_wdata[LOCK_BIT])
            lock_q <= 1'b1;
         if (reg_addr == REG_AW'(SEC_OFS))
            sec_q <= reg_wdata[SEC_BIT];
         if (!lock_q) begin
            for (int i = 0; i < NUM_RANGES; i++) begin
               if (reg_addr == desc_ofs(i)) begin
                  valid_q[i] <= reg_wdata[F_VALID];
                  perm_q[i]  <= perm_e'(reg_wdata[F_PERM +: 2]);
                  en_q[i]    <= reg_wdata[F_EN];
                  code_q[i]  <= reg_wdata[F_CODE +: CODE_W];
                  start_q[i] <= reg_wdata[DATA_W-1:GRAN_SHIFT];
                  if (i == 0) begin
                     ur_perm_q <= perm_e'(reg_wdata[F_UR_PERM +: 2]);
                     ur_en_q   <= reg_wdata[F_UR_EN];
                  end
               end
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (!sec_block) begin
         if (reg_addr == REG_AW'(CTRL_OFS))
            reg_rdata[LOCK_BIT] = lock_q;
         if (reg_addr == REG_AW'(SEC_OFS))
            reg_rdata[SEC_BIT] = sec_q;
         for (int i = 0; i < NUM_RANGES; i++) begin
            if (reg_addr == desc_ofs(i)) begin
               reg_rdata[F_VALID]              = valid_q[i];
               reg_rdata[F_PERM +: 2]          = perm_q[i];
               reg_rdata[F_EN]                 = en_q[i];
               reg_rdata[F_CODE +: CODE_W]     = code_q[i];
               reg_rdata[DATA_W-1:GRAN_SHIFT]  = start_q[i];
               if (i == 0) begin
                  reg_rdata[F_UR_PERM +: 2] = ur_perm_q;
                  reg_rdata[F_UR_EN]        = ur_en_q;
               end
            end
         end
      end
   end

   assign valid_o   = valid_q;
   assign perm_o    = perm_q;
   assign start_o   = start_q;
   assign code_o    = code_q;
   assign ur_perm_o = ur_perm_q;

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);                                               // R9
   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(valid_q) && $stable(en_q) && $stable(ur_perm_q)
                  && $stable(ur_en_q)));                                // R10
   AST_NONSEC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_nonsec && sec_q) |=> ($stable(valid_q) && $stable(lock_q)
                                           && $stable(sec_q) && $stable(ur_perm_q))); // R11
endmodule

// File: rtl/srg_range_match.sv
module srg_range_match
   import srg_pkg::*;
(
   input  logic               valid,
   input  logic [START_W-1:0] start,
   input  logic [CODE_W-1:0]  code,
   input  logic [START_W-1:0] page,
   output logic               hit
);
   logic [START_W-1:0] diff;
   logic               miss;

   always_comb begin
      diff = page ^ start;
      miss = 1'b0;
      for (int b = 0; b < START_W; b++) begin
         if (b >= int'(code))
            miss = miss | diff[b];
      end
      hit = valid & ~miss;
   end
endmodule

// File: rtl/srg_checker.sv
module srg_checker
   import srg_pkg::*;
#(
   parameter int NUM_RANGES = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_valid,
   input  logic [START_W-1:0]    acc_page,
   input  logic                  acc_write,
   input  logic [NUM_RANGES-1:0] valid_i,
   input  perm_e                 perm_i  [NUM_RANGES],
   input  logic [START_W-1:0]    start_i [NUM_RANGES],
   input  logic [CODE_W-1:0]     code_i  [NUM_RANGES],
   input  perm_e                 ur_perm_i,
   output logic                  chk_valid,
   output logic                  chk_allow
);
   logic [NUM_RANGES-1:0] hit;
   logic [NUM_RANGES-1:0] sel;
   perm_e                 win_perm;
   logic                  allow_d;

   for (genvar i = 0; i < NUM_RANGES; i++) begin : g_match
      srg_range_match u_match (
         .valid (valid_i[i]),
         .start (start_i[i]),
         .code  (code_i[i]),
         .page  (acc_page),
         .hit   (hit[i])
      );
   end

   assign sel = hit & (~hit + NUM_RANGES'(1));

   always_comb begin
      win_perm = ur_perm_i;
      for (int i = NUM_RANGES - 1; i >= 0; i--) begin
         if (sel[i])
            win_perm = perm_i[i];
      end
      allow_d = perm_allows(win_perm, acc_write);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_valid <= 1'b0;
         chk_allow <= 1'b0;
      end else begin
         chk_valid <= acc_valid;
         if (acc_valid)
            chk_allow <= allow_d;
      end
   end

   AST_CHK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> chk_valid);                                         // R8
   AST_CHK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !chk_valid);                                       // R8
   AST_ABORT_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && win_perm == PERM_ABORT) |=> !chk_allow);            // R4
   AST_UNDEF_RW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && hit == '0 && ur_perm_i == PERM_RW) |=> chk_allow);  // R5
endmodule

// File: rtl/srg_guard.sv
module srg_guard
   import srg_pkg::*;
#(
   parameter int NUM_RANGES = 16,
   parameter int REG_AW     = 12,
   parameter int DESC_BASE  = 'h80,
   parameter int CTRL_OFS   = 'h44,
   parameter int SEC_OFS    = 'h48,
   parameter int LOCK_BIT   = 31,
   parameter int SEC_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_nonsec,
   output logic [31:0]       reg_rdata,
   input  logic              acc_valid,
   input  logic [31:0]       acc_addr,
   input  logic              acc_write,
   output logic              chk_valid,
   output logic              chk_allow
);
   localparam int DESC_END = DESC_BASE + 8 * NUM_RANGES;

   if (NUM_RANGES < 1 || NUM_RANGES > 16) begin : g_bad_count
      $error("srg_guard: NUM_RANGES must lie in 1..16");
   end
   if (DESC_END > (1 << REG_AW)) begin : g_bad_span
      $error("srg_guard: descriptor block exceeds register offset space");
   end
   if (LOCK_BIT >= DATA_W || SEC_BIT >= DATA_W) begin : g_bad_bit
      $error("srg_guard: control bit position out of range");
   end
   if ((CTRL_OFS >= DESC_BASE && CTRL_OFS < DESC_END) ||
       (SEC_OFS >= DESC_BASE && SEC_OFS < DESC_END) || CTRL_OFS == SEC_OFS) begin : g_bad_map
      $error("srg_guard: control offsets collide");
   end

   logic [NUM_RANGES-1:0] valid_w;
   perm_e                 perm_w  [NUM_RANGES];
   logic [START_W-1:0]    start_w [NUM_RANGES];
   logic [CODE_W-1:0]     code_w  [NUM_RANGES];
   perm_e                 ur_perm_w;
   logic                  unused_lsb;

   assign unused_lsb = ^acc_addr[GRAN_SHIFT-1:0];

   srg_regs #(
      .NUM_RANGES (NUM_RANGES),
      .REG_AW     (REG_AW),
      .DESC_BASE  (DESC_BASE),
      .CTRL_OFS   (CTRL_OFS),
      .SEC_OFS    (SEC_OFS),
      .LOCK_BIT   (LOCK_BIT),
      .SEC_BIT    (SEC_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_nonsec (reg_nonsec),
      .reg_rdata  (reg_rdata),
      .valid_o    (valid_w),
      .perm_o     (perm_w),
      .start_o    (start_w),
      .code_o     (code_w),
      .ur_perm_o  (ur_perm_w)
   );

   srg_checker #(
      .NUM_RANGES (NUM_RANGES)
   ) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_page  (acc_addr[ADDR_W-1:GRAN_SHIFT]),
      .acc_write (acc_write),
      .valid_i   (valid_w),
      .perm_i    (perm_w),
      .start_i   (start_w),
      .code_i    (code_w),
      .ur_perm_i (ur_perm_w),
      .chk_valid (chk_valid),
      .chk_allow (chk_allow)
   );
endmodule

// File: tb/sim_srg_guard.sv
`timescale 1ns/1ps
module sim_srg_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        reg_nonsec = 1'b0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        acc_write = 1'b0;
   logic        chk_valid;
   logic        chk_allow;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   srg_guard u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_nonsec(reg_nonsec), .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_write(acc_write),
      .chk_valid(chk_valid), .chk_allow(chk_allow)
   );

   // {address, write, expected allow}
   localparam logic [33:0] VEC [13] = '{
      {32'h400F_FFFF, 1'b0, 1'b1},
      {32'h4000_0000, 1'b1, 1'b0},
      {32'h4010_0000, 1'b1, 1'b1},
      {32'h4010_0000, 1'b0, 1'b0},
      {32'h401F_FFFF, 1'b0, 1'b0},
      {32'h4020_0000, 1'b0, 1'b1},
      {32'h8000_0000, 1'b0, 1'b0},
      {32'hFFFF_FFFF, 1'b1, 1'b0},
      {32'h7FFF_FFFF, 1'b1, 1'b1},
      {32'h2000_0000, 1'b0, 1'b0},
      {32'h203F_FFFF, 1'b1, 1'b0},
      {32'h2040_0000, 1'b0, 1'b1},
      {32'h6000_0000, 1'b1, 1'b1}
   };

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d, logic ns = 1'b0);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_nonsec = ns;
      @(negedge clk);
      reg_we = 1'b0; reg_nonsec = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d, input logic ns = 1'b0);
      @(negedge clk);
      reg_addr = a; reg_nonsec = ns;
      #1 d = reg_rdata;
      reg_nonsec = 1'b0;
   endtask

   task automatic access(logic [31:0] a, logic w, output logic v, output logic al);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_write = w;
      @(negedge clk);
      v = chk_valid; al = chk_allow;
      acc_valid = 1'b0;
   endtask

   task automatic check_access(string tag, logic [31:0] a, logic w, logic exp);
      logic v, al;
      access(a, w, v, al);
      check({tag, " valid"}, 32'(v), 32'd1);
      check({tag, " allow"}, 32'(al), 32'(exp));
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(12'h080, d); check("R1 desc0 reset", d, 32'h0);
      rd(12'h0F8, d); check("R1 desc15 reset", d, 32'h0);
      rd(12'h044, d); check("R1 lock reset", d, 32'h0);
      rd(12'h048, d); check("R1 sec reset", d, 32'h0);
      check("R8 idle chk_valid", 32'(chk_valid), 32'd0);
      check_access("R1 write allowed", 32'h4000_0000, 1'b1, 1'b1);
      check_access("R1 read allowed", 32'hFFFF_F000, 1'b0, 1'b1);
      @(negedge clk);
      check("R8 valid drops", 32'(chk_valid), 32'd0);

      // configuration
      wr(12'h080, 32'h4000_044B);          // RO 1MB, en flags set (R12)
      wr(12'h088, 32'h4000_04F5);          // WO 2MB, bits 6:4 written
      wr(12'h090, 32'h8000_0987);          // abort 2GB
      wr(12'h098, 32'h2030_0507);          // abort 4MB, unaligned start
      wr(12'h0A0, 32'h6000_0406);          // invalid

      rd(12'h080, d); check("R2 R12 desc0 readback", d, 32'h4000_044B);
      rd(12'h088, d); check("R2 desc1 bits 6:4 read 0", d, 32'h4000_0485);
      rd(12'h098, d); check("R2 desc3 readback", d, 32'h2030_0507);
      wr(12'h084, 32'hFFFF_FFFF);
      rd(12'h084, d); check("R2 high word reads 0", d, 32'h0);
      wr(12'h0FC, 32'hFFFF_FFFF);
      rd(12'h0FC, d); check("R2 last high word reads 0", d, 32'h0);
      rd(12'h0F8, d); check("R2 high write no effect on desc15", d, 32'h0);

      // vector walk: R3 R4 R5 R6 R7 R12
      for (int k = 0; k < 13; k++) begin
         check_access($sformatf("R3 R4 R5 R6 R7 vector %0d", k),
                      VEC[k][33:2], VEC[k][1], VEC[k][0]);
      end

      // R5 fallback permission changed to read only
      wr(12'h080, 32'h4000_045B);
      check_access("R5 undefined write denied", 32'h7FFF_FFFF, 1'b1, 1'b0);
      check_access("R5 undefined read allowed", 32'h7FFF_FFFF, 1'b0, 1'b1);

      // R3 code 31 covers everything, in slot 5 (lower slots win by R6)
      wr(12'h0A8, 32'h0000_0F83);          // code 31, RO
      check_access("R3 code 31 covers all", 32'h7FFF_FFFF, 1'b1, 1'b0);
      check_access("R6 lower slot still wins", 32'h4010_0000, 1'b1, 1'b1);
      wr(12'h0A8, 32'h0000_0000);

      // R11 security gating
      wr(12'h048, 32'h0000_0001);
      rd(12'h048, d); check("R11 sec bit set", d, 32'h1);
      wr(12'h0A0, 32'h6000_0407, 1'b1);   // non-secure: ignored
      rd(12'h0A0, d); check("R11 nonsec write ignored", d, 32'h6000_0406);
      rd(12'h080, d, 1'b1); check("R11 nonsec read zero", d, 32'h0);
      check_access("R11 slot 4 still invalid", 32'h6000_0000, 1'b0, 1'b1);
      wr(12'h048, 32'h0000_0000, 1'b1);   // non-secure clear ignored
      rd(12'h048, d); check("R11 nonsec clear ignored", d, 32'h1);
      wr(12'h048, 32'h0000_0000);
      rd(12'h080, d, 1'b1); check("R11 nonsec read after clear", d, 32'h4000_045B);

      // R9 R10 lock
      wr(12'h044, 32'h8000_0000);
      rd(12'h044, d); check("R9 lock set", d, 32'h8000_0000);
      wr(12'h044, 32'h0000_0000);
      rd(12'h044, d); check("R9 lock sticky", d, 32'h8000_0000);
      wr(12'h090, 32'h0000_0000);
      rd(12'h090, d); check("R10 locked desc unchanged", d, 32'h8000_0987);
      check_access("R10 locked verdict unchanged", 32'h8000_0000, 1'b0, 1'b0);
      wr(12'h080, 32'h4000_044B);
      check_access("R10 locked fallback unchanged", 32'h7FFF_FFFF, 1'b1, 1'b0);

      // R9 reset clears lock
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(12'h044, d); check("R9 reset clears lock", d, 32'h0);
      rd(12'h090, d); check("R1 desc2 after reset", d, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule